// File: doc/BRIEF.md
# Programmable Parallel I/O Interface

This block connects a processor bus to 24 peripheral lines arranged as three 8-bit ports: P, Q and a split port R. Software sets up the ports through an 8-bit bidirectional data bus. A two-bit address picks a port or the configuration register, and active-low chip-select, read and write strobes qualify each access. Every bus line and pad is a plain synchronous signal sampled on the system clock. Each pad is modelled as three separate vectors: an input, an output value and an output enable.

The lines form two groups. The high group is port P together with the upper half of port R. The low group is port Q together with the lower half of port R. A configuration word puts each group in one of two modes. In direction mode, the 8-bit port and the 4-bit half are each set as input or output. In handshake mode, the 8-bit port moves data under a strobe/acknowledge protocol. In that mode, three lines of the group's half of port R carry the strobe or acknowledge, the buffer flag and the interrupt request, and the fourth line stays general purpose. A second kind of control write sets or clears one line of port R without touching the stored configuration.

The peripheral paces traffic. In handshake input mode the peripheral may strobe only while the buffer-full flag is low. In handshake output mode the processor may write only after the output-full line has gone high again. The block never stalls the bus.

Top module: `ppi_core`

## Requirements
- R1: After reset every output enable (port P, port Q, port R) is 0 and a read of the configuration register returns 0x9B.
- R2: Address 0 selects port P, 1 port Q, 2 port R and 3 the configuration register. bus_oe is high only while cs_n and rd_n are both low. A write with cs_n high changes nothing.
- R3: A control write with bit 7 = 1 stores a configuration word. In that word, bits 6:5 nonzero select handshake mode for the high group, bit 4 = 1 makes port P an input, and bit 3 = 1 makes the upper half of port R an input. Bit 2 = 1 selects handshake mode for the low group, bit 1 = 1 makes port Q an input, and bit 0 = 1 makes the lower half of port R an input. In direction mode, an output line has its enable at 1 and an input line has it at 0.
- R4: A read of the configuration register returns 1 in bit 7 and the stored configuration in bits 6:0.
- R5: Storing any configuration word clears the output latches of ports P, Q and R to 0.
- R6: A control write with bit 7 = 0 sets port R line number bits 3:1 to the value in bit 0 and leaves the stored configuration unchanged.
- R7: In direction mode, a read of an output port or half returns its latch. A read of a port R input half returns the live pad value. A read of a direction-mode input port returns the pad.
- R8: In handshake mode, line 0 of the group's half of port R is the strobe/acknowledge input, line 1 is the flag output, line 2 is the interrupt output, and line 3 follows the half's direction bit. For the high group these are R4 to R7; for the low group they are R0 to R3.
- R9: In handshake input mode, a falling strobe captures the port pads into the input latch and sets the flag line (active high). Later reads return the captured byte even if the pads change.
- R10: The interrupt enable of a handshake group is set or cleared by a set/reset command aimed at the group's strobe/acknowledge line (R4 or R0). The interrupt line rises only when the enable is 1.
- R11: In handshake input mode, a read of the port clears the interrupt line in the cycle after the read begins. The flag line clears in the cycle after the read ends.
- R12: In handshake output mode, a write to the port loads it, drives the flag line low (output full, active low) and clears the interrupt line. A falling acknowledge returns the flag line to high and raises the interrupt line if the enable is 1.
- R13: While cs_n is high, the port output values and port output enables hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port / configuration register select |
| bus_in | input | 8 | Data from processor |
| bus_out | output | 8 | Data to processor |
| bus_oe | output | 1 | Data bus drive enable |
| pa_in | input | 8 | Port P pad input |
| pa_out | output | 8 | Port P pad output value |
| pa_oe | output | 8 | Port P pad output enable |
| pb_in | input | 8 | Port Q pad input |
| pb_out | output | 8 | Port Q pad output value |
| pb_oe | output | 8 | Port Q pad output enable |
| pc_in | input | 8 | Port R pad input |
| pc_out | output | 8 | Port R pad output value |
| pc_oe | output | 8 | Port R pad output enable |

## Verification
The bench builds the block at its default port width of 8, the only width the 8-bit configuration word can address. That size covers every group mode: direction mode with each half set separately, handshake input on the high group and handshake output on the low group. It also lets the bench check that the set/reset command lands either on a latch or on an interrupt enable, depending on the mode. The mixed-direction reads of port R show whether a half returns its latch or its live pads.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int NGRP   = 2;

  localparam logic [ADDR_W-1:0] SEL_PA  = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_PB  = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_PC  = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_CTL = 2'd3;

  // stored bits 6:0 after reset: both groups direction mode, all inputs
  localparam logic [BUS_W-2:0] CTL_RESET = 7'h1B;

  typedef struct packed {
    logic mode1;
    logic port_in;
    logic half_in;
  } grp_cfg_t;

  typedef struct packed {
    logic       cfg_load;
    logic       wr_port;
    logic       wr_half;
    logic       rd_start;
    logic       rd_end;
    logic       bsr;
    logic [1:0] bit_sel;
    logic       bit_val;
  } grp_cmd_t;
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_sel,
  output logic              wr_go,
  output logic              rd_go,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_addr_q
);
  logic wr_sel, wr_q, rd_q;

  assign rd_sel  = ~cs_n & ~rd_n;
  assign wr_sel  = ~cs_n & ~wr_n;
  assign wr_go   = wr_sel & ~wr_q;
  assign rd_go   = rd_sel & ~rd_q;
  assign rd_done = rd_q & ~rd_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      wr_q <= wr_sel;
      rd_q <= rd_sel;
      if (rd_go) rd_addr_q <= addr;
    end
  end
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_go,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BUS_W-1:0]          din,
  input  logic                      rd_go,
  input  logic                      rd_done,
  input  logic [ADDR_W-1:0]         rd_addr_q,
  output logic [BUS_W-2:0]          ctl_q,
  output grp_cfg_t [NGRP-1:0]       cfg,
  output grp_cmd_t [NGRP-1:0]       cmd
);
  logic ctl_wr;

  assign ctl_wr = wr_go && (addr == SEL_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n)                ctl_q <= CTL_RESET;
    else if (ctl_wr && din[7]) ctl_q <= din[6:0];
  end

  // group 1: port P + upper half; group 0: port Q + lower half
  assign cfg[1].mode1   = ctl_q[6] | ctl_q[5];
  assign cfg[1].port_in = ctl_q[4];
  assign cfg[1].half_in = ctl_q[3];
  assign cfg[0].mode1   = ctl_q[2];
  assign cfg[0].port_in = ctl_q[1];
  assign cfg[0].half_in = ctl_q[0];

  for (genvar g = 0; g < NGRP; g++) begin : g_cmd
    localparam logic [ADDR_W-1:0] PSEL = (g == 1) ? SEL_PA : SEL_PB;
    assign cmd[g].cfg_load = ctl_wr & din[7];
    assign cmd[g].bsr      = ctl_wr & ~din[7] & (din[3] == 1'(g));
    assign cmd[g].bit_sel  = din[2:1];
    assign cmd[g].bit_val  = din[0];
    assign cmd[g].wr_port  = wr_go && (addr == PSEL);
    assign cmd[g].wr_half  = wr_go && (addr == SEL_PC);
    assign cmd[g].rd_start = rd_go && (addr == PSEL);
    assign cmd[g].rd_end   = rd_done && (rd_addr_q == PSEL);
  end
endmodule

// File: rtl/ppi_group.sv
module ppi_group
  import ppi_pkg::*;
#(
  parameter int PORT_W = BUS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  grp_cfg_t                 cfg,
  input  grp_cmd_t                 cmd,
  input  logic [PORT_W-1:0]        port_din,
  input  logic [PORT_W/2-1:0]      half_din,
  input  logic [PORT_W-1:0]        port_pin,
  input  logic [PORT_W/2-1:0]      half_pin,
  output logic [PORT_W-1:0]        port_out,
  output logic [PORT_W-1:0]        port_oe,
  output logic [PORT_W-1:0]        port_rd,
  output logic [PORT_W/2-1:0]      half_out,
  output logic [PORT_W/2-1:0]      half_oe,
  output logic [PORT_W/2-1:0]      half_rd
);
  localparam int HALF_W  = PORT_W / 2;
  localparam int HS_STB  = 0;
  localparam int HS_FLAG = 1;
  localparam int HS_IRQ  = 2;

  logic [PORT_W-1:0] out_lat, in_lat;
  logic [HALF_W-1:0] half_lat;
  logic ibf, obf, irq, inte, stb_q, stb_fall;

  assign stb_fall = stb_q & ~half_pin[HS_STB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_lat  <= '0;
      in_lat   <= '0;
      half_lat <= '0;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      irq      <= 1'b0;
      inte     <= 1'b0;
      stb_q    <= 1'b1;
    end else begin
      stb_q <= half_pin[HS_STB];
      if (cmd.cfg_load) begin
        out_lat  <= '0;
        half_lat <= '0;
        ibf      <= 1'b0;
        obf      <= 1'b0;
        irq      <= 1'b0;
        inte     <= 1'b0;
      end else begin
        if (cmd.wr_port) begin
          out_lat <= port_din;
          if (cfg.mode1 && !cfg.port_in) begin
            obf <= 1'b1;
            irq <= 1'b0;
          end
        end
        if (cmd.wr_half) half_lat <= half_din;
        if (cmd.bsr) begin
          if (cfg.mode1 && cmd.bit_sel == 2'(HS_STB)) inte <= cmd.bit_val;
          else                                     half_lat[cmd.bit_sel] <= cmd.bit_val;
        end
        if (cfg.mode1 && cfg.port_in) begin
          if (cmd.rd_start) irq <= 1'b0;
          if (cmd.rd_end)   ibf <= 1'b0;
          if (stb_fall) begin
            in_lat <= port_pin;
            ibf    <= 1'b1;
            if (inte) irq <= 1'b1;
          end
        end else if (cfg.mode1) begin
          if (stb_fall) begin
            obf <= 1'b0;
            if (inte) irq <= 1'b1;
          end
        end
      end
    end
  end

  assign port_oe  = {PORT_W{~cfg.port_in}};
  assign port_out = out_lat;
  assign port_rd  = cfg.port_in ? (cfg.mode1 ? in_lat : port_pin) : out_lat;

  always_comb begin
    half_oe  = {HALF_W{~cfg.half_in}};
    half_out = half_lat;
    if (cfg.mode1) begin
      half_oe[HS_STB]   = 1'b0;
      half_oe[HS_FLAG]  = 1'b1;
      half_oe[HS_IRQ]   = 1'b1;
      half_out[HS_FLAG] = cfg.port_in ? ibf : ~obf;
      half_out[HS_IRQ]  = irq;
    end
  end

  for (genvar i = 0; i < HALF_W; i++) begin : g_hrd
    assign half_rd[i] = half_oe[i] ? half_out[i] : half_pin[i];
  end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  input  logic [BUS_W-1:0]  pa_in,
  output logic [BUS_W-1:0]  pa_out,
  output logic [BUS_W-1:0]  pa_oe,
  input  logic [BUS_W-1:0]  pb_in,
  output logic [BUS_W-1:0]  pb_out,
  output logic [BUS_W-1:0]  pb_oe,
  input  logic [BUS_W-1:0]  pc_in,
  output logic [BUS_W-1:0]  pc_out,
  output logic [BUS_W-1:0]  pc_oe
);
  localparam int HALF_W = BUS_W / 2;

  logic rd_sel, wr_go, rd_go, rd_done;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [BUS_W-2:0]  ctl_q;
  grp_cfg_t [NGRP-1:0] cfg;
  grp_cmd_t [NGRP-1:0] cmd;

  logic [BUS_W-1:0]  g_pin  [NGRP];
  logic [BUS_W-1:0]  g_out  [NGRP];
  logic [BUS_W-1:0]  g_oe   [NGRP];
  logic [BUS_W-1:0]  g_rd   [NGRP];
  logic [HALF_W-1:0] h_out  [NGRP];
  logic [HALF_W-1:0] h_oe   [NGRP];
  logic [HALF_W-1:0] h_rd   [NGRP];

  ppi_bus_if u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .rd_sel(rd_sel), .wr_go(wr_go), .rd_go(rd_go),
    .rd_done(rd_done), .rd_addr_q(rd_addr_q)
  );

  ppi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .addr(addr), .din(bus_in),
    .rd_go(rd_go), .rd_done(rd_done), .rd_addr_q(rd_addr_q),
    .ctl_q(ctl_q), .cfg(cfg), .cmd(cmd)
  );

  assign g_pin[1] = pa_in;
  assign g_pin[0] = pb_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    ppi_group #(.PORT_W(BUS_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[g]), .cmd(cmd[g]),
      .port_din(bus_in),
      .half_din(bus_in[g*HALF_W +: HALF_W]),
      .port_pin(g_pin[g]),
      .half_pin(pc_in[g*HALF_W +: HALF_W]),
      .port_out(g_out[g]), .port_oe(g_oe[g]), .port_rd(g_rd[g]),
      .half_out(h_out[g]), .half_oe(h_oe[g]), .half_rd(h_rd[g])
    );
    assign pc_out[g*HALF_W +: HALF_W] = h_out[g];
    assign pc_oe[g*HALF_W +: HALF_W]  = h_oe[g];
  end

  assign pa_out = g_out[1];
  assign pa_oe  = g_oe[1];
  assign pb_out = g_out[0];
  assign pb_oe  = g_oe[0];

  assign bus_oe = rd_sel;

  always_comb begin
    bus_out = '0;
    if (rd_sel) begin
      unique case (addr)
        SEL_PA:  bus_out = g_rd[1];
        SEL_PB:  bus_out = g_rd[0];
        SEL_PC:  bus_out = {h_rd[1], h_rd[0]};
        default: bus_out = {1'b1, ctl_q};
      endcase
    end
  end
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk
  import ppi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  bus_out,
  input logic              bus_oe,
  input logic [BUS_W-1:0]  pa_out,
  input logic [BUS_W-1:0]  pa_oe,
  input logic [BUS_W-1:0]  pb_out,
  input logic [BUS_W-1:0]  pb_oe,
  input logic [BUS_W-1:0]  pc_in,
  input logic [BUS_W-1:0]  pc_out,
  input logic [BUS_W-1:0]  pc_oe
);
  // R2
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !bus_oe);

  // R4
  ctrl_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && addr == SEL_CTL) |-> bus_out[BUS_W-1]);

  // R13
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  // R13
  outlatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_out) && $stable(pb_out)));

  // R9
  strobe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pa_oe[0] && pc_oe[5] && !pc_oe[4] && $fell(pc_in[4]) && (cs_n || wr_n))
      |=> pc_out[5]);
endmodule

bind ppi_core ppi_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .bus_out(bus_out), .bus_oe(bus_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppi_core_test.sv
module ppi_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] bus_in = '0, pa_in = '0, pb_in = '0, pc_in = 8'h11;
  logic [7:0] bus_out, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic bus_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppi_core uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; bus_in = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic [7:0] mid_pc);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 d = bus_out;
    @(negedge clk);
    mid_pc = pc_out;
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_r(input int b);
    pc_in[b] = 1'b0;
    @(negedge clk);
    pc_in[b] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d, m;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    bus_rd(2'd3, d, m);
    check("R1 R4 ctrl readback", d, 8'h9B);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    addr = 2'd1; bus_in = 8'hFF; cs_n = 1'b1; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    check("R2 unselected write ignored", pb_out, 8'h00);
    rd_n = 1'b0;
    #1 check("R2 no drive when unselected", {7'd0, bus_oe}, 8'h00);
    @(negedge clk);
    rd_n = 1'b1;
    check("R13 outputs hold unselected", pa_out, 8'h00);
    bus_wr(2'd2, 8'h96);
    check("R2 port R write", pc_out, 8'h96);
    addr = 2'd1; cs_n = 1'b0; rd_n = 1'b0;
    #1 d = {7'd0, bus_oe};
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check("R2 drive during selected read", d, 8'h01);
  endtask

  task automatic t_mode0();
    logic [7:0] d, m;
    bus_wr(2'd3, 8'h80);
    check("R3 pa_oe all out", pa_oe, 8'hFF);
    check("R3 pb_oe all out", pb_oe, 8'hFF);
    check("R3 pc_oe all out", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h96);
    check("R7 pa_out", pa_out, 8'h5A);
    check("R7 pb_out", pb_out, 8'hC3);
    bus_rd(2'd0, d, m);
    check("R7 output port reads latch", d, 8'h5A);
    bus_wr(2'd3, 8'h88);
    check("R3 upper half input", pc_oe, 8'h0F);
    check("R5 port P latch cleared", pa_out, 8'h00);
    check("R5 port Q latch cleared", pb_out, 8'h00);
    check("R5 port R latch cleared", pc_out, 8'h00);
    pc_in = 8'hA5;
    bus_rd(2'd2, d, m);
    check("R7 port R mixed read", d, 8'hA0);
    pc_in = 8'h35;
    bus_rd(2'd2, d, m);
    check("R7 port R live pads", d, 8'h30);
    bus_rd(2'd3, d, m);
    check("R4 ctrl readback", d, 8'h88);
    bus_wr(2'd3, 8'h90);
    pa_in = 8'h3C;
    bus_rd(2'd0, d, m);
    check("R7 input port reads pads", d, 8'h3C);
    check("R3 port P input enable", pa_oe, 8'h00);
  endtask

  task automatic t_bsr();
    logic [7:0] d, m;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0B);
    check("R6 set line 5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h05);
    check("R6 set line 2", pc_out, 8'h24);
    bus_wr(2'd3, 8'h0A);
    check("R6 clear line 5", pc_out, 8'h04);
    bus_rd(2'd3, d, m);
    check("R6 config unchanged", d, 8'h80);
  endtask

  task automatic t_hs_in();
    logic [7:0] d, m;
    pc_in = 8'h11;
    bus_wr(2'd3, 8'hB0);
    check("R8 port R enables high group input", pc_oe, 8'hEF);
    check("R8 flags idle", pc_out & 8'h60, 8'h00);
    pa_in = 8'h77;
    pulse_r(4);
    check("R9 flag set by strobe", {7'd0, pc_out[5]}, 8'h01);
    check("R10 no interrupt when disabled", {7'd0, pc_out[6]}, 8'h00);
    pa_in = 8'h00;
    bus_rd(2'd0, d, m);
    check("R9 captured byte", d, 8'h77);
    check("R11 flag cleared after read", {7'd0, pc_out[5]}, 8'h00);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'hE1;
    pulse_r(4);
    check("R10 interrupt raised when enabled", pc_out & 8'h60, 8'h60);
    pa_in = 8'h42;
    bus_rd(2'd0, d, m);
    check("R9 second capture", d, 8'hE1);
    check("R11 interrupt clears at read start", m & 8'h60, 8'h20);
    check("R11 flag clears at read end", pc_out & 8'h60, 8'h00);
    bus_wr(2'd3, 8'h0F);
    check("R8 spare line follows latch", {7'd0, pc_out[7]}, 8'h01);
  endtask

  task automatic t_hs_out();
    pc_in = 8'h11;
    bus_wr(2'd3, 8'h84);
    check("R8 port R enables low group output", pc_oe, 8'hFE);
    check("R12 output-full idle high", pc_out, 8'h02);
    check("R3 port Q output", pb_oe, 8'hFF);
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd1, 8'h66);
    check("R12 port Q loaded", pb_out, 8'h66);
    check("R12 output-full low", pc_out, 8'h00);
    pulse_r(0);
    check("R12 ack releases and interrupts", pc_out, 8'h06);
    bus_wr(2'd1, 8'h11);
    check("R12 write clears interrupt", pc_out, 8'h00);
    bus_wr(2'd3, 8'h00);
    pulse_r(0);
    check("R10 ack without enable", pc_out, 8'h02);
    check("R12 port Q second value", pb_out, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_mode0();
    t_bsr();
    t_hs_in();
    t_hs_out();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule